// File: doc/BRIEF.md
# Synchronous FIFO with Programmable Threshold Flags

This block is a single-clock first-in first-out buffer of parameterized depth D. It reports its fill level through five active-low status flags: a read-side flag, a write-side flag, half-full, almost-empty and almost-full. The almost-empty offset n and the almost-full offset m are held in two internal registers. Software-side logic may rewrite them at any time after master reset.

While master reset is held, two inputs are captured. The first picks the output timing. In standard mode, each read strobe fetches the next word into the output register one clock later. In fall-through mode, the oldest word moves to the output register by itself. The output register then counts as an extra storage slot, so the capacity becomes D+1 words.

The second input picks the offset programming style and the reset value of both offsets. When it is high, offsets are shifted in one bit per serial-enable clock and both default to 1023. When it is low, offsets are written and read back as whole words and both default to 127. Each style ignores the other style's controls.

The offset loader uses two enumerated states, SEL_AE and SEL_AF. It starts in SEL_AE at reset. In serial style the serial pointer moves SEL_AE→SEL_AF after the last bit of the empty offset, and SEL_AF→SEL_AE after the last bit of the full offset. In parallel style, each offset write toggles the write pointer between SEL_AE and SEL_AF, and each readback toggles a separate read pointer in the same way.

The output stage has two states, OS_DRY (no word held) and OS_HELD (a word is presented):
- In fall-through mode, OS_DRY→OS_HELD is taken when storage is non-empty.
- In OS_HELD, a read with more words stored stays in OS_HELD and loads the next word.
- In OS_HELD, a read with storage empty takes OS_HELD→OS_DRY.
- In standard mode the stage never leaves OS_DRY.

Top module: `prog_flag_fifo`

## Requirements
- R1: Master reset (mrst_n low at a clock edge) empties the FIFO, returns the output register to 0 and sets every flag to its empty value for the latched mode. It loads both offsets with 1023 when load_style_sel is high and with 127 when it is low.
- R2: In standard mode, rd_side_n is 0 exactly when the word count is 0, and wr_side_n is 0 exactly when the count equals D.
- R3: In standard mode, the flags follow these thresholds on the count c:
  - aempty_n is 0 for c ≤ n;
  - half_n is 0 for c ≥ D/2+1;
  - afull_n is 0 for c ≥ D−m.
- R4: Words leave in the order they were written. In standard mode, dout shows the fetched word on the clock edge that accepts the read, and holds it until the next accepted read.
- R5: A write when no space is available is ignored, and so is a read when no word is available. Neither changes the count, the flags or the stored data.
- R6: A read and a write in the same cycle, with at least one word stored, leave the count and the flags unchanged.
- R7: In fall-through mode, the oldest word appears on dout without a read strobe, and rd_side_n is 0 exactly while such a word is presented. The capacity is D+1 words, and wr_side_n is 1 only when D+1 words are stored.
- R8: In fall-through mode, each threshold moves up by one word:
  - aempty_n is 0 for c ≤ n+1;
  - half_n is 0 for c ≥ D/2+2;
  - afull_n is 0 for c ≥ D+1−m.
- R9: In parallel style, successive ofs_wr strobes write ofs_din into the empty offset, then the full offset, alternating. Successive ofs_rd strobes return the empty offset, then the full offset, alternating. The value appears on ofs_dout on the edge that takes the strobe.
- R10: In serial style, each ser_en cycle stores ser_in as the next offset bit, least significant bit first. The OFS_W bits of the empty offset come first, then the OFS_W bits of the full offset. In serial style ofs_wr and ofs_rd are ignored; in parallel style ser_en is ignored.
- R11: The timing mode and the programming style change only while mrst_n is low. Changing fwft_sel or load_style_sel afterwards has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Synchronous master reset, active low |
| fwft_sel | input | 1 | Timing mode captured at reset: 1 fall-through, 0 standard |
| load_style_sel | input | 1 | Offset style captured at reset: 1 serial, 0 parallel |
| wr_en | input | 1 | Write strobe |
| din | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| dout | output | DATA_W | Output register |
| ofs_wr | input | 1 | Parallel offset write strobe |
| ofs_din | input | OFS_W | Parallel offset write value |
| ofs_rd | input | 1 | Parallel offset readback strobe |
| ofs_dout | output | OFS_W | Offset readback value |
| ser_en | input | 1 | Serial offset bit enable |
| ser_in | input | 1 | Serial offset bit |
| rd_side_n | output | 1 | Standard: empty (low when empty). Fall-through: output ready (low when a word is presented) |
| wr_side_n | output | 1 | Standard: full (low when full). Fall-through: input ready (high only when D+1 words are stored) |
| half_n | output | 1 | Half-full flag, active low |
| aempty_n | output | 1 | Almost-empty flag, active low |
| afull_n | output | 1 | Almost-full flag, active low |

## Verification
The FIFO is run in both timing modes with a small depth. It is filled one word at a time from empty to capacity and then drained. All five flags are compared at every count against thresholds computed from n, m, D and the mode, which separates the one-word shift of fall-through mode from standard mode. Writes at capacity, reads when empty, and simultaneous read-write pairs at full and at mid-level tell real transfers apart from ignored ones; these cases are checked through the data order and the flags. Offsets are programmed through both styles, with the other style's controls also toggled. Parallel readback confirms the alternation of the pointers and the style-dependent defaults.

// File: rtl/pff_pkg.sv
package pff_pkg;
    typedef enum logic {OUT_STD = 1'b0, OUT_FWFT = 1'b1} out_mode_e;
    typedef enum logic {LOAD_PAR = 1'b0, LOAD_SER = 1'b1} load_style_e;
    typedef enum logic {SEL_AE = 1'b0, SEL_AF = 1'b1} ofs_sel_e;
    typedef enum logic {OS_DRY = 1'b0, OS_HELD = 1'b1} os_state_e;

    typedef struct packed {
        logic rd_side;
        logic wr_side;
        logic half;
        logic aempty;
        logic afull;
    } flag_set_t;
endpackage

// File: rtl/pff_store.sv
module pff_store #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 16,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] head_data,
    output logic [CW-1:0]     ram_cnt
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr;
    logic [AW-1:0]     rptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST_ADDR) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            ram_cnt <= '0;
        end else begin
            if (push) begin
                wptr <= bump(wptr);
            end
            if (pop) begin
                rptr <= bump(rptr);
            end
            unique case ({push, pop})
                2'b10:   ram_cnt <= ram_cnt + 1'b1;
                2'b01:   ram_cnt <= ram_cnt - 1'b1;
                default: ram_cnt <= ram_cnt;
            endcase
        end
    end

    assign head_data = mem[rptr];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ram_cnt <= CW'(DEPTH)); // R5
    AST_PAIR_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(ram_cnt)); // R6
endmodule

// File: rtl/pff_outstage.sv
module pff_outstage
    import pff_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  out_mode_e         mode,
    input  logic              rd_en,
    input  logic [CW-1:0]     ram_cnt,
    input  logic [DATA_W-1:0] ram_head,
    output logic              pop,
    output logic              ovalid,
    output logic [DATA_W-1:0] dout
);
    os_state_e st, st_nxt;
    logic      load;
    logic      ram_has;

    assign ram_has = (ram_cnt != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= OS_DRY;
        end else begin
            st <= st_nxt;
        end
    end

    always_comb begin
        st_nxt = st;
        pop    = 1'b0;
        load   = 1'b0;
        unique case (st)
            OS_DRY: begin
                if (mode == OUT_FWFT) begin
                    if (ram_has) begin
                        pop    = 1'b1;
                        load   = 1'b1;
                        st_nxt = OS_HELD;
                    end
                end else if (rd_en && ram_has) begin
                    pop  = 1'b1;
                    load = 1'b1;
                end
            end
            OS_HELD: begin
                if (rd_en) begin
                    if (ram_has) begin
                        pop  = 1'b1;
                        load = 1'b1;
                    end else begin
                        st_nxt = OS_DRY;
                    end
                end
            end
            default: st_nxt = OS_DRY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (load) begin
            dout <= ram_head;
        end
    end

    assign ovalid = (st == OS_HELD);

    AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == OS_HELD && !rd_en) |=> (st == OS_HELD && $stable(dout))); // R7
    AST_STD_NEVER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OUT_STD) |-> (st == OS_DRY)); // R4
endmodule

// File: rtl/pff_offsets.sv
module pff_offsets
    import pff_pkg::*;
#(
    parameter int               OFS_W   = 10,
    parameter logic [OFS_W-1:0] DEF_SER = 10'h3FF,
    parameter logic [OFS_W-1:0] DEF_PAR = 10'h07F,
    localparam int              BW      = (OFS_W > 1) ? $clog2(OFS_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             style_raw,
    input  load_style_e      style,
    input  logic             ofs_wr,
    input  logic [OFS_W-1:0] ofs_din,
    input  logic             ofs_rd,
    input  logic             ser_en,
    input  logic             ser_in,
    output logic [OFS_W-1:0] ae_ofs,
    output logic [OFS_W-1:0] af_ofs,
    output logic [OFS_W-1:0] ofs_dout
);
    localparam logic [BW-1:0] LAST_BIT = BW'(OFS_W - 1);

    ofs_sel_e       ser_sel, ser_sel_nxt;
    ofs_sel_e       wr_sel,  wr_sel_nxt;
    ofs_sel_e       rd_sel,  rd_sel_nxt;
    logic [BW-1:0]  bidx,    bidx_nxt;
    logic           ser_go, par_wr_go, par_rd_go;

    function automatic ofs_sel_e other(input ofs_sel_e s);
        return (s == SEL_AE) ? SEL_AF : SEL_AE;
    endfunction

    assign ser_go    = (style == LOAD_SER) && ser_en;
    assign par_wr_go = (style == LOAD_PAR) && ofs_wr;
    assign par_rd_go = (style == LOAD_PAR) && ofs_rd;

    always_comb begin
        ser_sel_nxt = ser_sel;
        bidx_nxt    = bidx;
        wr_sel_nxt  = wr_sel;
        rd_sel_nxt  = rd_sel;
        if (ser_go) begin
            unique case (ser_sel)
                SEL_AE, SEL_AF: begin
                    if (bidx == LAST_BIT) begin
                        bidx_nxt    = '0;
                        ser_sel_nxt = other(ser_sel);
                    end else begin
                        bidx_nxt = bidx + 1'b1;
                    end
                end
                default: ser_sel_nxt = SEL_AE;
            endcase
        end
        if (par_wr_go) begin
            wr_sel_nxt = other(wr_sel);
        end
        if (par_rd_go) begin
            rd_sel_nxt = other(rd_sel);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_sel <= SEL_AE;
            wr_sel  <= SEL_AE;
            rd_sel  <= SEL_AE;
            bidx    <= '0;
        end else begin
            ser_sel <= ser_sel_nxt;
            wr_sel  <= wr_sel_nxt;
            rd_sel  <= rd_sel_nxt;
            bidx    <= bidx_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ae_ofs   <= style_raw ? DEF_SER : DEF_PAR;
            af_ofs   <= style_raw ? DEF_SER : DEF_PAR;
            ofs_dout <= '0;
        end else begin
            if (ser_go) begin
                if (ser_sel == SEL_AE) begin
                    ae_ofs[bidx] <= ser_in;
                end else begin
                    af_ofs[bidx] <= ser_in;
                end
            end
            if (par_wr_go) begin
                if (wr_sel == SEL_AE) begin
                    ae_ofs <= ofs_din;
                end else begin
                    af_ofs <= ofs_din;
                end
            end
            if (par_rd_go) begin
                ofs_dout <= (rd_sel == SEL_AE) ? ae_ofs : af_ofs;
            end
        end
    end

    AST_SERIAL_IDLE_IN_PAR: assert property (@(posedge clk) disable iff (!rst_n)
        (style == LOAD_PAR) |=> ($stable(ser_sel) && $stable(bidx))); // R10
    AST_READBACK_IDLE_IN_SER: assert property (@(posedge clk) disable iff (!rst_n)
        (style == LOAD_SER) |=> $stable(ofs_dout)); // R10
endmodule

// File: rtl/pff_flags.sv
module pff_flags
    import pff_pkg::*;
#(
    parameter int  DEPTH = 16,
    parameter int  OFS_W = 10,
    localparam int OW    = $clog2(DEPTH + 2),
    localparam int FW    = ((OW > OFS_W) ? OW : OFS_W) + 2
) (
    input  out_mode_e        mode,
    input  logic [OW-1:0]    occ,
    input  logic             ovalid,
    input  logic [OFS_W-1:0] ae_ofs,
    input  logic [OFS_W-1:0] af_ofs,
    output flag_set_t        flags
);
    logic [FW-1:0] c, n, m, shift, dep;

    always_comb begin
        c     = FW'(occ);
        n     = FW'(ae_ofs);
        m     = FW'(af_ofs);
        shift = (mode == OUT_FWFT) ? FW'(1) : FW'(0);
        dep   = FW'(DEPTH);

        if (mode == OUT_FWFT) begin
            flags.rd_side = !ovalid;
            flags.wr_side = (c == dep + 1'b1);
        end else begin
            flags.rd_side = (c != '0);
            flags.wr_side = (c != dep);
        end
        flags.aempty = !(c <= n + shift);
        flags.half   = !(c >= FW'(DEPTH / 2) + 1'b1 + shift);
        flags.afull  = !(c + m >= dep + shift);
    end
endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo
    import pff_pkg::*;
#(
    parameter int               DATA_W  = 9,
    parameter int               DEPTH   = 16,
    parameter int               OFS_W   = 10,
    parameter logic [OFS_W-1:0] DEF_SER = 10'h3FF,
    parameter logic [OFS_W-1:0] DEF_PAR = 10'h07F
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              fwft_sel,
    input  logic              load_style_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_en,
    output logic [DATA_W-1:0] dout,
    input  logic              ofs_wr,
    input  logic [OFS_W-1:0]  ofs_din,
    input  logic              ofs_rd,
    output logic [OFS_W-1:0]  ofs_dout,
    input  logic              ser_en,
    input  logic              ser_in,
    output logic              rd_side_n,
    output logic              wr_side_n,
    output logic              half_n,
    output logic              aempty_n,
    output logic              afull_n
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int OW = $clog2(DEPTH + 2);

    out_mode_e         omode;
    load_style_e       lstyle;
    logic              push, pop, ovalid;
    logic [CW-1:0]     ram_cnt;
    logic [DATA_W-1:0] ram_head;
    logic [OW-1:0]     occ, cap;
    logic [OFS_W-1:0]  ae_ofs, af_ofs;
    flag_set_t         flags;

    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            omode  <= fwft_sel ? OUT_FWFT : OUT_STD;
            lstyle <= load_style_sel ? LOAD_SER : LOAD_PAR;
        end
    end

    assign push = wr_en && ((ram_cnt != CW'(DEPTH)) || pop);
    assign occ  = OW'(ram_cnt) + OW'(ovalid);
    assign cap  = (omode == OUT_FWFT) ? OW'(DEPTH + 1) : OW'(DEPTH);

    pff_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
        .clk       (clk),
        .rst_n     (mrst_n),
        .push      (push),
        .pop       (pop),
        .wdata     (din),
        .head_data (ram_head),
        .ram_cnt   (ram_cnt)
    );

    pff_outstage #(.DATA_W(DATA_W), .DEPTH(DEPTH)) outstage_i (
        .clk      (clk),
        .rst_n    (mrst_n),
        .mode     (omode),
        .rd_en    (rd_en),
        .ram_cnt  (ram_cnt),
        .ram_head (ram_head),
        .pop      (pop),
        .ovalid   (ovalid),
        .dout     (dout)
    );

    pff_offsets #(.OFS_W(OFS_W), .DEF_SER(DEF_SER), .DEF_PAR(DEF_PAR)) offsets_i (
        .clk       (clk),
        .rst_n     (mrst_n),
        .style_raw (load_style_sel),
        .style     (lstyle),
        .ofs_wr    (ofs_wr),
        .ofs_din   (ofs_din),
        .ofs_rd    (ofs_rd),
        .ser_en    (ser_en),
        .ser_in    (ser_in),
        .ae_ofs    (ae_ofs),
        .af_ofs    (af_ofs),
        .ofs_dout  (ofs_dout)
    );

    pff_flags #(.DEPTH(DEPTH), .OFS_W(OFS_W)) flags_i (
        .mode   (omode),
        .occ    (occ),
        .ovalid (ovalid),
        .ae_ofs (ae_ofs),
        .af_ofs (af_ofs),
        .flags  (flags)
    );

    assign rd_side_n = flags.rd_side;
    assign wr_side_n = flags.wr_side;
    assign half_n    = flags.half;
    assign aempty_n  = flags.aempty;
    assign afull_n   = flags.afull;

    AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!mrst_n)
        $past(mrst_n) |-> ($stable(omode) && $stable(lstyle))); // R11
    AST_FULL_NO_GROWTH: assert property (@(posedge clk) disable iff (!mrst_n)
        (occ == cap && !rd_en) |=> (occ == $past(occ))); // R5
    AST_EMPTY_NO_SHRINK: assert property (@(posedge clk) disable iff (!mrst_n)
        (occ == '0 && !wr_en) |=> (occ == '0)); // R5
endmodule

// File: tb/prog_flag_fifo_tb_top.sv
module prog_flag_fifo_tb_top;
    localparam int D  = 8;
    localparam int DW = 8;
    localparam int OW = 10;

    logic          clk = 1'b0;
    logic          mrst_n = 1'b0;
    logic          fwft_sel = 1'b0, load_style_sel = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          ofs_wr = 1'b0, ofs_rd = 1'b0;
    logic [OW-1:0] ofs_din = '0;
    logic [OW-1:0] ofs_dout;
    logic          ser_en = 1'b0, ser_in = 1'b0;
    logic          rd_side_n, wr_side_n, half_n, aempty_n, afull_n;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int            cnt, qh, qt, n_ofs, m_ofs;
    bit            fw;
    logic [DW-1:0] q [16];
    logic [DW-1:0] seq, std_last;

    always #2.5 clk = ~clk;

    prog_flag_fifo #(.DATA_W(DW), .DEPTH(D), .OFS_W(OW)) dut_i (
        .clk(clk), .mrst_n(mrst_n), .fwft_sel(fwft_sel), .load_style_sel(load_style_sel),
        .wr_en(wr_en), .din(din), .rd_en(rd_en), .dout(dout),
        .ofs_wr(ofs_wr), .ofs_din(ofs_din), .ofs_rd(ofs_rd), .ofs_dout(ofs_dout),
        .ser_en(ser_en), .ser_in(ser_in),
        .rd_side_n(rd_side_n), .wr_side_n(wr_side_n), .half_n(half_n),
        .aempty_n(aempty_n), .afull_n(afull_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h (count=%0d)", tag, act, exp, cnt);
        end
    endtask

    task automatic chk_flags(input string tag);
        logic [4:0] e;
        e[4] = fw ? (cnt == 0) : (cnt != 0);
        e[3] = fw ? (cnt == D + 1) : (cnt != D);
        e[2] = !(cnt >= D / 2 + 1 + int'(fw));
        e[1] = !(cnt <= n_ofs + int'(fw));
        e[0] = !(cnt + m_ofs >= D + int'(fw));
        chk(tag, {27'd0, rd_side_n, wr_side_n, half_n, aempty_n, afull_n}, {27'd0, e});
    endtask

    task automatic do_reset(input bit f, input bit ser);
        @(negedge clk);
        mrst_n = 1'b0; fwft_sel = f; load_style_sel = ser;
        repeat (3) @(negedge clk);
        mrst_n = 1'b1;
        fwft_sel = !f; load_style_sel = !ser;   // R11: ignored after reset
        @(negedge clk);
        fw = f; cnt = 0; qh = 0; qt = 0; std_last = '0;
    endtask

    task automatic op(input bit w, input bit r, input string tag);
        bit rd_ok, wr_ok;
        int cap;
        logic [DW-1:0] popped;
        cap   = fw ? D + 1 : D;
        rd_ok = r && (cnt > 0);
        wr_ok = w && ((cnt < cap) || rd_ok);
        popped = q[qh % 16];
        wr_en = w; rd_en = r; din = seq;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        @(negedge clk);
        if (rd_ok) begin qh++; cnt--; end
        if (wr_ok) begin q[qt % 16] = seq; qt++; cnt++; end
        seq++;
        chk_flags(tag);
        if (!fw) begin
            if (rd_ok) std_last = popped;
            chk({tag, " R4 data"}, {24'd0, dout}, {24'd0, std_last});
        end else if (cnt > 0) begin
            chk({tag, " R7 head"}, {24'd0, dout}, {24'd0, q[qh % 16]});
        end
    endtask

    task automatic par_wr(input logic [OW-1:0] v);
        @(negedge clk); ofs_wr = 1'b1; ofs_din = v;
        @(negedge clk); ofs_wr = 1'b0;
    endtask

    task automatic readback(input string tag, input logic [OW-1:0] exp);
        @(negedge clk); ofs_rd = 1'b1;
        @(negedge clk); ofs_rd = 1'b0;
        chk(tag, {22'd0, ofs_dout}, {22'd0, exp});
    endtask

    task automatic ser_load(input logic [OW-1:0] a, input logic [OW-1:0] b);
        for (int i = 0; i < 2 * OW; i++) begin
            @(negedge clk);
            ser_en = 1'b1;
            ser_in = (i < OW) ? a[i] : b[i - OW];
        end
        @(negedge clk); ser_en = 1'b0;
    endtask

    initial begin
        seq = 8'h10;
        // ---------- standard mode, parallel style ----------
        do_reset(1'b0, 1'b0);
        n_ofs = 127; m_ofs = 127;
        chk_flags("R1 reset flags std");
        chk("R1 reset dout", {24'd0, dout}, 32'd0);
        readback("R1 R9 default empty ofs", 10'd127);
        readback("R1 R9 default full ofs", 10'd127);
        par_wr(10'd2); par_wr(10'd3);
        n_ofs = 2; m_ofs = 3;
        readback("R9 empty ofs", 10'd2);
        readback("R9 full ofs", 10'd3);
        ser_load(10'd0, 10'd0);                 // R10: ignored in parallel style
        readback("R10 serial ignored (ae)", 10'd2);
        readback("R10 serial ignored (af)", 10'd3);
        chk_flags("R11 mode held std");
        op(1'b0, 1'b1, "R5 read empty std");
        for (int k = 0; k < D; k++) op(1'b1, 1'b0, "R2 R3 fill std");
        op(1'b1, 1'b0, "R5 write full std");
        op(1'b1, 1'b1, "R6 rw at full std");
        for (int k = 0; k < D; k++) op(1'b0, 1'b1, "R2 R3 R4 drain std");
        op(1'b0, 1'b1, "R5 read empty after drain");
        for (int k = 0; k < 3; k++) op(1'b1, 1'b0, "R3 refill std");
        op(1'b1, 1'b1, "R6 rw mid std");
        op(1'b1, 1'b1, "R6 rw mid std again");
        op(1'b1, 1'b0, "R3 r3_ almost-empty edge");

        // ---------- fall-through mode, serial style ----------
        do_reset(1'b1, 1'b1);
        n_ofs = 1023; m_ofs = 1023;
        chk_flags("R1 R8 reset flags fwft");
        op(1'b1, 1'b0, "R1 serial default thresholds");
        op(1'b0, 1'b1, "R7 drain one");
        @(negedge clk); ofs_rd = 1'b1;
        @(negedge clk); ofs_rd = 1'b0;
        chk("R10 readback ignored in serial", {22'd0, ofs_dout}, 32'd0);
        ser_load(10'd2, 10'd3);
        n_ofs = 2; m_ofs = 3;
        par_wr(10'd0); par_wr(10'd0);          // R10: ignored in serial style
        chk_flags("R10 R11 serial loaded, fwft held");
        for (int k = 0; k < D + 1; k++) op(1'b1, 1'b0, "R7 R8 fill fwft");
        op(1'b1, 1'b0, "R5 write full fwft");
        op(1'b1, 1'b1, "R6 rw at full fwft");
        for (int k = 0; k < D + 1; k++) op(1'b0, 1'b1, "R7 R8 drain fwft");
        op(1'b0, 1'b1, "R5 read empty fwft");
        op(1'b1, 1'b0, "R7 single word fwft");
        op(1'b1, 1'b1, "R6 rw one word fwft");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule